// File: doc/BRIEF.md
# Interrupt Status and Queue Control Register Bank

This block keeps the event flags of a two-wire bus controller, one enable per flag, the controller's queue-control bits, and a soft-reset strobe. The bus engine pulses `evt_i` when something happens on the bus. The matching flag latches and stays set until software clears it. `irq_o` rises one clock after any flag whose enable is set.

Each register occupies a 16-byte window with three write offsets. Offset +0 replaces the register contents. Offset +4 sets every bit that is written as one. Offset +8 clears every bit that is written as one. Because of the set and clear offsets, software can change single flags or enables without a read-modify-write, and it cannot undo an event that the engine raised at the same moment. A write that puts a one in the top data bit of the control window resets the whole bank.

Top module: `irq_bank`

## Requirements
- R1: After `rst_ni` is deasserted, every register reads zero, and `irq_o`, `queue_run_o` and `pio_mode_o` are low.
- R2: A write at 0x40 loads the event register. Bits [7:0] are the flags: 7 bus idle, 6 engine done, 5 target did not acknowledge, 4 transfer too long, 3 early stop, 2 arbitration lost, 1 stop seen as target, 0 addressed as target. Bit k+8 is the enable of flag k.
- R3: A write at 0x44 ORs the written ones into the event register and leaves every other bit unchanged.
- R4: A write at 0x48 clears the written ones in the event register and leaves every other bit unchanged.
- R5: When `evt_i[k]` is high at a clock edge, flag k is set after that edge. It stays set until software clears it.
- R6: If an event and a software write at 0x40 or 0x48 reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_o` is registered. It is high in the cycle after a cycle in which some flag k and enable k+8 are both set, and low in the cycle after a cycle in which no such pair exists.
- R8: The queue register at 0x60 (replace), 0x64 (set) and 0x68 (clear) stores only bit 5, which drives `queue_run_o`, and bit 2, which drives `pio_mode_o`. Every other bit reads zero.
- R9: A write at 0x00 or 0x04 with data bit 31 set zeroes the event register, the queue register and `irq_o` at that edge, even if an event arrives in the same cycle. The same write with bit 31 clear has no effect.
- R10: `rdata_o` is combinational. It shows the register that owns the 16-byte window selected by `addr_i`, at any offset within the window. The control window and unmapped windows read zero.
- R11: A write at offset +0xC of a window, or at an unmapped window, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 8 | Byte address; bits [7:4] select the window, bits [3:2] the offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| evt_i | input | 8 | Event pulses from the bus engine, one per flag |
| irq_o | output | 1 | Interrupt request |
| queue_run_o | output | 1 | Queue run enable |
| pio_mode_o | output | 1 | Programmed I/O queue mode select |

## Verification
The bench drives an event in the same cycle as a clear and in the same cycle as a replace write. A design that lets software win would lose the event, and the flag would read back as zero. It checks `irq_o` one cycle and two cycles after an enabled flag is cleared. A combinational interrupt would drop one cycle early, and a missing enable term would raise it for flags that are not enabled. It also starts a soft reset while every event input is high, writes at the unused +0xC offset, and writes to the control window with bit 31 clear. A wrong decode in any of these cases would leave state behind or corrupt the bank.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } reg_op_e;

  localparam logic [3:0] GRP_CTRL  = 4'h0;
  localparam logic [3:0] GRP_EVT   = 4'h4;
  localparam logic [3:0] GRP_QUEUE = 4'h6;

  localparam int QUE_W    = 8;
  localparam int QRUN_BIT = 5;
  localparam int QPIO_BIT = 2;
  localparam logic [QUE_W-1:0] QUE_KEEP = QUE_W'((1 << QRUN_BIT) | (1 << QPIO_BIT));
endpackage

// File: rtl/irq_alias_reg.sv
`timescale 1ns/1ps
module irq_alias_reg
  import irq_bank_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] KEEP = {W{1'b1}}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic         wr_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (wr_i) begin
      case (op_i)
        OP_WR:   nxt = wdata_i;
        OP_SET:  nxt = q | wdata_i;
        OP_CLR:  nxt = q & ~wdata_i;
        default: nxt = q;
      endcase
    end
    // hardware set overrides any software update
    nxt = (nxt | hw_set_i) & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= '0;
    else if (clr_all_i) q <= '0;
    else                q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_reduce.sv
`timescale 1ns/1ps
module irq_reduce #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_o <= 1'b0;
    else if (clr_all_i) irq_o <= 1'b0;
    else                irq_o <= |(stat_i & en_i);
  end
endmodule

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o,
  output logic              queue_run_o,
  output logic              pio_mode_o
);
  localparam int INT_W    = 2 * EVT_W;
  localparam int GRP_W    = ADDR_W - 4;
  localparam int SRST_BIT = DATA_W - 1;

  logic [GRP_W-1:0] grp;
  reg_op_e          op;
  logic             srst, evt_wr, que_wr;
  logic [INT_W-1:0] int_q;
  logic [QUE_W-1:0] que_q;
  logic             unused_bits;

  assign grp = addr_i[ADDR_W-1:4];
  assign op  = reg_op_e'(addr_i[3:2]);

  assign srst   = wr_en_i && (grp == GRP_W'(GRP_CTRL)) &&
                  (op == OP_WR || op == OP_SET) && wdata_i[SRST_BIT];
  assign evt_wr = wr_en_i && (grp == GRP_W'(GRP_EVT));
  assign que_wr = wr_en_i && (grp == GRP_W'(GRP_QUEUE));

  irq_alias_reg #(.W(INT_W)) evt_reg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(srst),
    .wr_i     (evt_wr),
    .op_i     (op),
    .wdata_i  (wdata_i[INT_W-1:0]),
    .hw_set_i ({{EVT_W{1'b0}}, evt_i}),
    .q_o      (int_q)
  );

  irq_alias_reg #(.W(QUE_W), .KEEP(QUE_KEEP)) que_reg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(srst),
    .wr_i     (que_wr),
    .op_i     (op),
    .wdata_i  (wdata_i[QUE_W-1:0]),
    .hw_set_i ('0),
    .q_o      (que_q)
  );

  irq_reduce #(.N(EVT_W)) irq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(srst),
    .stat_i   (int_q[EVT_W-1:0]),
    .en_i     (int_q[INT_W-1:EVT_W]),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (grp == GRP_W'(GRP_EVT))        rdata_o = DATA_W'(int_q);
    else if (grp == GRP_W'(GRP_QUEUE)) rdata_o = DATA_W'(que_q);
  end

  assign queue_run_o = que_q[QRUN_BIT];
  assign pio_mode_o  = que_q[QPIO_BIT];
  assign unused_bits = ^{addr_i[1:0], wdata_i[SRST_BIT-1:INT_W]};
endmodule

module irq_bank_chk #(
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int QUE_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [EVT_W-1:0]  evt_i,
  input logic              irq_o,
  input logic [2*EVT_W-1:0] int_q,
  input logic [QUE_W-1:0]  que_q
);
  localparam int INT_W = 2 * EVT_W;

  logic [ADDR_W-5:0] grp;
  logic [1:0]        off;
  logic              srst, set_wr, clr_wr, any_en, unused_chk;
  logic [INT_W-1:0]  clr_mask;

  assign grp      = addr_i[ADDR_W-1:4];
  assign off      = addr_i[3:2];
  assign srst     = wr_en_i && grp == '0 && off <= 2'd1 && wdata_i[DATA_W-1];
  assign set_wr   = wr_en_i && grp == (ADDR_W-4)'(4) && off == 2'd1;
  assign clr_wr   = wr_en_i && grp == (ADDR_W-4)'(4) && off == 2'd2;
  assign clr_mask = wdata_i[INT_W-1:0] & ~{{EVT_W{1'b0}}, evt_i};
  assign any_en   = |(int_q[EVT_W-1:0] & int_q[INT_W-1:EVT_W]);
  assign unused_chk = ^{addr_i[1:0], wdata_i};

  // R3
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && !srst) |=> ((int_q & $past(wdata_i[INT_W-1:0])) == $past(wdata_i[INT_W-1:0])));

  // R4
  clr_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !srst) |=> ((int_q & $past(clr_mask)) == '0));

  // R5 R6
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst |=> ((int_q[EVT_W-1:0] & $past(evt_i)) == $past(evt_i)));

  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_en && !srst) |=> irq_o);

  // R7
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en |=> !irq_o);

  // R9
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (int_q == '0 && que_q == '0 && !irq_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && evt_i == '0) |=> ($stable(int_q) && $stable(que_q)));
endmodule

bind irq_bank irq_bank_chk #(
  .EVT_W(EVT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QUE_W(irq_bank_pkg::QUE_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .evt_i  (evt_i),
  .irq_o  (irq_o),
  .int_q  (int_q),
  .que_q  (que_q)
);

// File: tb/irq_bank_tb_top.sv
`timescale 1ns/1ps
module irq_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  evt_i = '0;
  logic        irq_o, queue_run_o, pio_mode_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o),
    .queue_run_o(queue_run_o), .pio_mode_o(pio_mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk_i);
    wr_en_i = we; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 8'h00);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h40, d); check("R1 event reg", d, 32'h0);
    rd(8'h60, d); check("R1 queue reg", d, 32'h0);
    check("R1 outputs", {29'h0, irq_o, queue_run_o, pio_mode_o}, 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr(8'h40, 32'h0000_A55A);
    rd(8'h40, d); check("R2 replace", d, 32'h0000_A55A);
    @(negedge clk_i);
    check("R7 no enabled flag", {31'h0, irq_o}, 32'h0);
    wr(8'h40, 32'h0000_0101);
    check("R7 latency one", {31'h0, irq_o}, 32'h0);
    @(negedge clk_i);
    check("R7 enabled flag", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0000_0300);
    rd(8'h40, d); check("R3 set enables", d, 32'h0000_0300);
    wr(8'h44, 32'h0000_0014);
    rd(8'h40, d); check("R3 set flags", d, 32'h0000_0314);
    wr(8'h48, 32'h0000_0010);
    rd(8'h40, d); check("R4 clear one", d, 32'h0000_0304);
    @(negedge clk_i);
    check("R7 flag 2 not enabled", {31'h0, irq_o}, 32'h0);
    wr(8'h44, 32'h0000_0400);
    @(negedge clk_i);
    check("R7 flag 2 enabled", {31'h0, irq_o}, 32'h1);
    wr(8'h48, 32'h0000_0004);
    check("R7 held one cycle after clear", {31'h0, irq_o}, 32'h1);
    @(negedge clk_i);
    check("R7 drops after clear", {31'h0, irq_o}, 32'h0);
    rd(8'h40, d); check("R4 others kept", d, 32'h0000_0700);
  endtask

  task automatic t_evt();
    logic [31:0] d;
    wr(8'h40, 32'h0);
    cyc(1'b0, 8'h40, 32'h0, 8'h81);
    rd(8'h40, d); check("R5 event latch", d, 32'h0000_0081);
    repeat (3) @(negedge clk_i);
    rd(8'h40, d); check("R5 event held", d, 32'h0000_0081);
    cyc(1'b1, 8'h40, 32'h0, 8'h20);
    rd(8'h40, d); check("R6 event beats replace", d, 32'h0000_0020);
    wr(8'h44, 32'h0000_00C0);
    cyc(1'b1, 8'h48, 32'h0000_00FF, 8'h08);
    rd(8'h40, d); check("R6 event beats clear", d, 32'h0000_0008);
  endtask

  task automatic t_queue();
    logic [31:0] d;
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, d); check("R8 only two bits kept", d, 32'h0000_0024);
    check("R8 outputs on", {30'h0, queue_run_o, pio_mode_o}, 32'h3);
    wr(8'h68, 32'h0000_0020);
    rd(8'h60, d); check("R8 clear run", d, 32'h0000_0004);
    check("R8 run off", {30'h0, queue_run_o, pio_mode_o}, 32'h1);
    wr(8'h64, 32'h0000_0020);
    rd(8'h64, d); check("R8 set run, R10 alias read", d, 32'h0000_0024);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    wr(8'h40, 32'h0000_1234);
    wr(8'h4C, 32'h0000_FFFF);
    rd(8'h40, d); check("R11 offset C ignored", d, 32'h0000_1234);
    wr(8'h80, 32'h0000_FFFF);
    rd(8'h40, d); check("R11 unmapped ignored", d, 32'h0000_1234);
    rd(8'h80, d); check("R10 unmapped reads zero", d, 32'h0);
    rd(8'h48, d); check("R10 clear alias reads reg", d, 32'h0000_1234);
    wr(8'h00, 32'h7FFF_FFFF);
    rd(8'h40, d); check("R9 bit31 clear no reset", d, 32'h0000_1234);
    rd(8'h60, d); check("R9 queue kept", d, 32'h0000_0024);
    rd(8'h00, d); check("R10 control reads zero", d, 32'h0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(8'h40, 32'h0000_FFFF);
    @(negedge clk_i);
    check("R7 all enabled", {31'h0, irq_o}, 32'h1);
    cyc(1'b1, 8'h04, 32'h8000_0000, 8'hFF);
    rd(8'h40, d); check("R9 set alias reset beats event", d, 32'h0);
    rd(8'h60, d); check("R9 queue zero", d, 32'h0);
    check("R9 irq zero", {29'h0, irq_o, queue_run_o, pio_mode_o}, 32'h0);
    wr(8'h44, 32'h0000_0101);
    wr(8'h00, 32'h8000_0000);
    rd(8'h40, d); check("R9 plain reset", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_plain();
    t_setclr();
    t_evt();
    t_queue();
    t_ignore();
    t_srst();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule